// File: doc/BRIEF.md
# Dual-Write Configuration Register with Field Legalization

This block holds the mode word of a block-cipher engine. A new value reaches the engine only after the same 32-bit word has been written twice in a row while the engine reports idle. If the second word differs from the first, nothing is committed and a sticky recoverable error flag goes high. A read of the register cancels a half-finished update, so the next write always starts a fresh pair. Writes while the engine is busy are dropped.

On commit, each one-hot field is legalized before it is stored. An unknown operation becomes encrypt, an unknown chaining mode becomes "no mode", an unknown key size becomes 256 bits, and an unknown reseed interval becomes "every block". A committed update also produces a one-cycle new-message pulse, which clears the error flag.

A small two-bit side register sits beside the main word. Its write access is governed by an enable bit that can only be cleared, which locks the register until reset.

Top module: `ctl_shadow_reg`

## Requirements
- R1: After reset the stored word `cfg_o` is 0x1181 (operation encrypt, mode none, key 128, reseed every block, sideload 0, manual 0); `upd_err_o` and `new_msg_o` are 0; `aux_o` is 2'b01; `aux_unlocked_o` is 1.
- R2: A write while `idle_i`=1 that immediately follows an earlier accepted write of the identical 32-bit word commits the legalized low 16 bits; `cfg_o` shows the value the cycle after the second write. A lone first write changes no output.
- R3: If the second write of a pair differs from the first, `cfg_o` is unchanged and `upd_err_o` goes to 1 the next cycle. The pair is then finished, so the next write counts as a first write.
- R4: A cycle with `rd_en_i`=1 cancels a pending first write. A write in the same cycle as a read counts as a first write.
- R5: Writes while `idle_i`=0 are ignored: they neither commit nor advance or cancel the pairing.
- R6: A commit makes `new_msg_o` high for exactly one cycle (the same cycle `cfg_o` updates), and it clears `upd_err_o` in that same cycle.
- R7: Operation field bits [1:0]: 2'b01 means encrypt and 2'b10 means decrypt; these are kept. 2'b00 and 2'b11 are stored as 2'b01.
- R8: Mode field bits [7:2] is one-hot (ECB 1, CBC 2, CFB 4, OFB 8, CTR 16, NONE 32). A zero or multi-hot value is stored as 6'b100000.
- R9: Key-size field bits [10:8] (128 = 3'b001, 192 = 3'b010, 256 = 3'b100). A zero or multi-hot value is stored as 3'b100. When parameter `ALLOW_192`=0, 3'b010 is also stored as 3'b100.
- R10: Reseed-interval field bits [14:12] (every block 3'b001, every 64 3'b010, every 8192 3'b100). A zero or multi-hot value is stored as 3'b001.
- R11: Sideload bit 11 and manual bit 15 are stored as written; bits 31:16 take part in the pair comparison but are not stored.
- R12: `aux_wr_en_i` loads `aux_wdata_i` into `aux_o` only while `aux_unlocked_o`=1. Writing 0 on `lock_wdata_i` with `lock_wr_en_i` clears `aux_unlocked_o`; writing 1 has no effect. Once cleared, the lock stays cleared until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| idle_i | input | 1 | Engine idle indication; writes accepted only when 1 |
| wr_en_i | input | 1 | Main register write strobe |
| rd_en_i | input | 1 | Main register read strobe |
| wdata_i | input | 32 | Main register write data |
| aux_wr_en_i | input | 1 | Side register write strobe |
| aux_wdata_i | input | 2 | Side register write data |
| lock_wr_en_i | input | 1 | Lock bit write strobe |
| lock_wdata_i | input | 1 | Lock bit write data (0 clears) |
| cfg_o | output | 16 | Stored legalized word |
| op_o | output | 2 | Operation field |
| mode_o | output | 6 | Chaining mode field |
| keylen_o | output | 3 | Key size field |
| sideload_o | output | 1 | Sideload select |
| rate_o | output | 3 | Reseed interval field |
| manual_o | output | 1 | Manual start select |
| upd_err_o | output | 1 | Sticky mismatch flag |
| new_msg_o | output | 1 | One-cycle commit pulse |
| aux_o | output | 2 | Side register value |
| aux_unlocked_o | output | 1 | Side register write enable |

## Verification
The bench targets mismatched pairs, a read placed between two matching writes, a read in the same cycle as a write, and writes issued while busy followed by a single write once idle. A design that commits on the first write, or that lets a busy-period write arm the pair, would update `cfg_o` one write too early. Every illegal code of each one-hot field is sent, and a second instance with the 192-bit size disabled is run alongside; a missing legalization shows up as a raw code on the field output. The side register is written after the lock is cleared, and the lock is written with 1 after it is cleared; a lock that can be set again, or that does not block writes, changes `aux_o` or `aux_unlocked_o`.

// File: rtl/ctl_shadow_pkg.sv
package ctl_shadow_pkg;

    localparam int WORD_W   = 32;
    localparam int CFG_W    = 16;

    localparam int OP_LSB   = 0;
    localparam int OP_W     = 2;
    localparam int MODE_LSB = 2;
    localparam int MODE_W   = 6;
    localparam int KL_LSB   = 8;
    localparam int KL_W     = 3;
    localparam int SL_BIT   = 11;
    localparam int RATE_LSB = 12;
    localparam int RATE_W   = 3;
    localparam int MAN_BIT  = 15;

    localparam logic [OP_W-1:0]   OP_ENC    = 2'b01;
    localparam logic [MODE_W-1:0] MODE_NONE = 6'b100000;
    localparam logic [KL_W-1:0]   KL_192    = 3'b010;
    localparam logic [KL_W-1:0]   KL_256    = 3'b100;
    localparam logic [RATE_W-1:0] RATE_ONE  = 3'b001;

    typedef struct packed {
        logic              armed;
        logic [WORD_W-1:0] stage;
        logic [CFG_W-1:0]  cfg;
        logic              err;
        logic              nm;
    } shadow_state_t;

    typedef struct packed {
        logic [1:0] val;
        logic       unlocked;
    } aux_state_t;

endpackage

// File: rtl/ctl_field_sanitize.sv
module ctl_field_sanitize
    import ctl_shadow_pkg::*;
#(
    parameter bit ALLOW_192 = 1'b1
) (
    input  logic [CFG_W-1:0] raw_i,
    output logic [CFG_W-1:0] clean_o
);

    logic [OP_W-1:0]   op_raw;
    logic [MODE_W-1:0] mode_raw;
    logic [KL_W-1:0]   kl_raw;
    logic [RATE_W-1:0] rate_raw;
    logic [KL_W-1:0]   kl_clean;

    assign op_raw   = raw_i[OP_LSB   +: OP_W];
    assign mode_raw = raw_i[MODE_LSB +: MODE_W];
    assign kl_raw   = raw_i[KL_LSB   +: KL_W];
    assign rate_raw = raw_i[RATE_LSB +: RATE_W];

    generate
        if (ALLOW_192) begin : g_kl_full
            assign kl_clean = $onehot(kl_raw) ? kl_raw : KL_256;
        end else begin : g_kl_no192
            assign kl_clean = ($onehot(kl_raw) && (kl_raw != KL_192)) ? kl_raw : KL_256;
        end
    endgenerate

    always_comb begin
        clean_o                      = raw_i;
        clean_o[OP_LSB   +: OP_W]    = $onehot(op_raw)   ? op_raw   : OP_ENC;
        clean_o[MODE_LSB +: MODE_W]  = $onehot(mode_raw) ? mode_raw : MODE_NONE;
        clean_o[KL_LSB   +: KL_W]    = kl_clean;
        clean_o[RATE_LSB +: RATE_W]  = $onehot(rate_raw) ? rate_raw : RATE_ONE;
    end

endmodule

// File: rtl/ctl_aux_lock.sv
module ctl_aux_lock
    import ctl_shadow_pkg::*;
#(
    parameter logic [1:0] AUX_RESET = 2'b01
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       aux_wr_en_i,
    input  logic [1:0] aux_wdata_i,
    input  logic       lock_wr_en_i,
    input  logic       lock_wdata_i,
    output logic [1:0] aux_o,
    output logic       unlocked_o
);

    aux_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (aux_wr_en_i && st_q.unlocked) begin
            st_d.val = aux_wdata_i;
        end
        if (lock_wr_en_i && !lock_wdata_i) begin
            st_d.unlocked = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.val      <= AUX_RESET;
            st_q.unlocked <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign aux_o      = st_q.val;
    assign unlocked_o = st_q.unlocked;

endmodule

// File: rtl/ctl_shadow_reg.sv
module ctl_shadow_reg
    import ctl_shadow_pkg::*;
#(
    parameter bit              ALLOW_192 = 1'b1,
    parameter logic [15:0]     RESET_CFG = 16'h1181,
    parameter logic [1:0]      AUX_RESET = 2'b01
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        idle_i,
    input  logic        wr_en_i,
    input  logic        rd_en_i,
    input  logic [31:0] wdata_i,
    input  logic        aux_wr_en_i,
    input  logic [1:0]  aux_wdata_i,
    input  logic        lock_wr_en_i,
    input  logic        lock_wdata_i,
    output logic [15:0] cfg_o,
    output logic [1:0]  op_o,
    output logic [5:0]  mode_o,
    output logic [2:0]  keylen_o,
    output logic        sideload_o,
    output logic [2:0]  rate_o,
    output logic        manual_o,
    output logic        upd_err_o,
    output logic        new_msg_o,
    output logic [1:0]  aux_o,
    output logic        aux_unlocked_o
);

    shadow_state_t    sh_d, sh_q;
    logic [CFG_W-1:0] clean_w;
    logic             wr_ok;

    ctl_field_sanitize #(
        .ALLOW_192 (ALLOW_192)
    ) u_san (
        .raw_i   (wdata_i[CFG_W-1:0]),
        .clean_o (clean_w)
    );

    assign wr_ok = wr_en_i && idle_i;

    always_comb begin
        sh_d    = sh_q;
        sh_d.nm = 1'b0;
        if (wr_ok) begin
            if (sh_q.armed && !rd_en_i) begin
                sh_d.armed = 1'b0;
                if (wdata_i == sh_q.stage) begin
                    sh_d.cfg = clean_w;
                    sh_d.nm  = 1'b1;
                    sh_d.err = 1'b0;
                end else begin
                    sh_d.err = 1'b1;
                end
            end else begin
                sh_d.armed = 1'b1;
                sh_d.stage = wdata_i;
            end
        end else if (rd_en_i) begin
            sh_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q.armed <= 1'b0;
            sh_q.stage <= '0;
            sh_q.cfg   <= RESET_CFG;
            sh_q.err   <= 1'b0;
            sh_q.nm    <= 1'b0;
        end else begin
            sh_q <= sh_d;
        end
    end

    ctl_aux_lock #(
        .AUX_RESET (AUX_RESET)
    ) u_aux (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .aux_wr_en_i  (aux_wr_en_i),
        .aux_wdata_i  (aux_wdata_i),
        .lock_wr_en_i (lock_wr_en_i),
        .lock_wdata_i (lock_wdata_i),
        .aux_o        (aux_o),
        .unlocked_o   (aux_unlocked_o)
    );

    assign cfg_o      = sh_q.cfg;
    assign op_o       = sh_q.cfg[OP_LSB   +: OP_W];
    assign mode_o     = sh_q.cfg[MODE_LSB +: MODE_W];
    assign keylen_o   = sh_q.cfg[KL_LSB   +: KL_W];
    assign sideload_o = sh_q.cfg[SL_BIT];
    assign rate_o     = sh_q.cfg[RATE_LSB +: RATE_W];
    assign manual_o   = sh_q.cfg[MAN_BIT];
    assign upd_err_o  = sh_q.err;
    assign new_msg_o  = sh_q.nm;

endmodule

// File: rtl/ctl_shadow_chk.sv
module ctl_shadow_chk #(
    parameter bit ALLOW_192 = 1'b1
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        idle_i,
    input logic        wr_en_i,
    input logic [15:0] cfg_o,
    input logic [1:0]  op_o,
    input logic [5:0]  mode_o,
    input logic [2:0]  keylen_o,
    input logic [2:0]  rate_o,
    input logic        upd_err_o,
    input logic        new_msg_o,
    input logic [1:0]  aux_o,
    input logic        aux_unlocked_o
);

    a_r2_no_write_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(cfg_o));

    a_r5_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !idle_i |=> $stable(cfg_o));

    a_r3_err_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(upd_err_o) |-> $past(wr_en_i && idle_i));

    a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        new_msg_o |=> !new_msg_o);

    a_r6_pulse_clears_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
        new_msg_o |-> !upd_err_o);

    a_r7_op_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot(op_o));

    a_r8_mode_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot(mode_o));

    a_r9_keylen_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot(keylen_o) && (ALLOW_192 || keylen_o != 3'b010));

    a_r10_rate_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot(rate_o));

    a_r12_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !aux_unlocked_o |=> !aux_unlocked_o);

    a_r12_locked_aux_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !aux_unlocked_o |=> $stable(aux_o));

endmodule

bind ctl_shadow_reg ctl_shadow_chk #(
    .ALLOW_192 (ALLOW_192)
) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .idle_i         (idle_i),
    .wr_en_i        (wr_en_i),
    .cfg_o          (cfg_o),
    .op_o           (op_o),
    .mode_o         (mode_o),
    .keylen_o       (keylen_o),
    .rate_o         (rate_o),
    .upd_err_o      (upd_err_o),
    .new_msg_o      (new_msg_o),
    .aux_o          (aux_o),
    .aux_unlocked_o (aux_unlocked_o)
);

// File: tb/tb_ctl_shadow_reg.sv
module tb_ctl_shadow_reg;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        idle, wr, rd, auxwe, lockwe, lockd;
    logic [31:0] wdata;
    logic [1:0]  auxd;

    logic [15:0] cfg_a, cfg_b;
    logic [1:0]  op_a, op_b, aux_a, aux_b;
    logic [5:0]  mode_a, mode_b;
    logic [2:0]  kl_a, kl_b, rate_a, rate_b;
    logic        sl_a, sl_b, man_a, man_b, err_a, err_b, nm_a, nm_b, unl_a, unl_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctl_shadow_reg dut (
        .clk_i(clk), .rst_ni(rst_n), .idle_i(idle), .wr_en_i(wr), .rd_en_i(rd),
        .wdata_i(wdata), .aux_wr_en_i(auxwe), .aux_wdata_i(auxd),
        .lock_wr_en_i(lockwe), .lock_wdata_i(lockd),
        .cfg_o(cfg_a), .op_o(op_a), .mode_o(mode_a), .keylen_o(kl_a),
        .sideload_o(sl_a), .rate_o(rate_a), .manual_o(man_a),
        .upd_err_o(err_a), .new_msg_o(nm_a), .aux_o(aux_a), .aux_unlocked_o(unl_a)
    );

    ctl_shadow_reg #(.ALLOW_192(1'b0)) dut_no192 (
        .clk_i(clk), .rst_ni(rst_n), .idle_i(idle), .wr_en_i(wr), .rd_en_i(rd),
        .wdata_i(wdata), .aux_wr_en_i(auxwe), .aux_wdata_i(auxd),
        .lock_wr_en_i(lockwe), .lock_wdata_i(lockd),
        .cfg_o(cfg_b), .op_o(op_b), .mode_o(mode_b), .keylen_o(kl_b),
        .sideload_o(sl_b), .rate_o(rate_b), .manual_o(man_b),
        .upd_err_o(err_b), .new_msg_o(nm_b), .aux_o(aux_b), .aux_unlocked_o(unl_b)
    );

    typedef struct {
        logic [15:0] cfg;
        logic [15:0] cfg_nk;
        logic        err;
        logic        nm;
        logic [1:0]  aux;
        logic        unl;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;

    // reference model state
    logic        m_armed;
    logic [31:0] m_stage;
    logic [15:0] m_cfg, m_cfg_nk;
    logic        m_err, m_nm, m_unl;
    logic [1:0]  m_aux;

    function automatic logic [15:0] legalize(logic [15:0] w, bit allow192);
        logic [15:0] r = w;
        case (w[1:0])
            2'b01, 2'b10: r[1:0] = w[1:0];
            default:      r[1:0] = 2'b01;
        endcase
        case (w[7:2])
            6'd1, 6'd2, 6'd4, 6'd8, 6'd16, 6'd32: r[7:2] = w[7:2];
            default:                              r[7:2] = 6'd32;
        endcase
        case (w[10:8])
            3'b001, 3'b100: r[10:8] = w[10:8];
            3'b010:         r[10:8] = allow192 ? 3'b010 : 3'b100;
            default:        r[10:8] = 3'b100;
        endcase
        case (w[14:12])
            3'b001, 3'b010, 3'b100: r[14:12] = w[14:12];
            default:                r[14:12] = 3'b001;
        endcase
        return r;
    endfunction

    function automatic logic [31:0] mk(logic [1:0] op, logic [5:0] md, logic [2:0] kl,
                                       logic sl, logic [2:0] rt, logic mn);
        return {16'hA5C3, mn, rt, sl, kl, md, op};
    endfunction

    task automatic push_exp(string tag);
        exp_t e;
        e.cfg = m_cfg; e.cfg_nk = m_cfg_nk; e.err = m_err; e.nm = m_nm;
        e.aux = m_aux; e.unl = m_unl; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic step(logic w, logic r, logic i, logic [31:0] d,
                        logic aw, logic [1:0] ad, logic lw, logic ld, string tag);
        @(negedge clk);
        wr = w; rd = r; idle = i; wdata = d; auxwe = aw; auxd = ad; lockwe = lw; lockd = ld;
        @(posedge clk);
        m_nm = 1'b0;
        if (w && i) begin
            if (m_armed && !r) begin
                m_armed = 1'b0;
                if (d == m_stage) begin
                    m_cfg = legalize(d[15:0], 1'b1);
                    m_cfg_nk = legalize(d[15:0], 1'b0);
                    m_nm = 1'b1; m_err = 1'b0;
                end else begin
                    m_err = 1'b1;
                end
            end else begin
                m_armed = 1'b1; m_stage = d;
            end
        end else if (r) begin
            m_armed = 1'b0;
        end
        if (aw && m_unl) m_aux = ad;
        if (lw && !ld) m_unl = 1'b0;
        #1;
        push_exp(tag);
    endtask

    task automatic wr1(logic [31:0] d, string tag);
        step(1'b1, 1'b0, 1'b1, d, 1'b0, 2'b00, 1'b0, 1'b1, tag);
    endtask

    task automatic pair(logic [31:0] d, string tag);
        wr1(d, tag);
        wr1(d, tag);
    endtask

    task automatic nop(string tag);
        step(1'b0, 1'b0, 1'b1, 32'h0, 1'b0, 2'b00, 1'b0, 1'b1, tag);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            cur = exp_q.pop_front();
            n_checks++;
            if (cfg_a !== cur.cfg || cfg_b !== cur.cfg_nk || err_a !== cur.err ||
                nm_a !== cur.nm || aux_a !== cur.aux || unl_a !== cur.unl ||
                op_a !== cur.cfg[1:0] || mode_a !== cur.cfg[7:2] || kl_a !== cur.cfg[10:8] ||
                sl_a !== cur.cfg[11] || rate_a !== cur.cfg[14:12] || man_a !== cur.cfg[15]) begin
                n_errors++;
                $display("FAIL %s: actual cfg=%h cfg192off=%h err=%b nm=%b aux=%b unl=%b expected cfg=%h cfg192off=%h err=%b nm=%b aux=%b unl=%b",
                         cur.tag, cfg_a, cfg_b, err_a, nm_a, aux_a, unl_a,
                         cur.cfg, cur.cfg_nk, cur.err, cur.nm, cur.aux, cur.unl);
            end
        end
    end

    initial begin
        idle = 1'b1; wr = 1'b0; rd = 1'b0; wdata = '0; auxwe = 1'b0; auxd = '0;
        lockwe = 1'b0; lockd = 1'b1;
        m_armed = 1'b0; m_stage = '0; m_cfg = 16'h1181; m_cfg_nk = 16'h1181;
        m_err = 1'b0; m_nm = 1'b0; m_aux = 2'b01; m_unl = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        nop("R1 reset state");

        // R2: first write alone changes nothing, second commits
        wr1(mk(2'b10, 6'd1, 3'b001, 1'b0, 3'b001, 1'b0), "R2 first write no change");
        wr1(mk(2'b10, 6'd1, 3'b001, 1'b0, 3'b001, 1'b0), "R2 commit and R6 pulse");
        nop("R6 pulse lasts one cycle");

        // R3: mismatch
        wr1(mk(2'b01, 6'd2, 3'b100, 1'b0, 3'b010, 1'b0), "R3 first of mismatched pair");
        wr1(mk(2'b01, 6'd4, 3'b100, 1'b0, 3'b010, 1'b0), "R3 mismatch sets error");
        wr1(mk(2'b01, 6'd4, 3'b100, 1'b0, 3'b010, 1'b0), "R3 next write is a first write");
        wr1(mk(2'b01, 6'd4, 3'b100, 1'b0, 3'b010, 1'b0), "R6 commit clears error");
        // bits 31:16 take part in the compare (R11)
        wr1(mk(2'b10, 6'd8, 3'b001, 1'b0, 3'b001, 1'b0), "R11 upper bits first");
        wr1(mk(2'b10, 6'd8, 3'b001, 1'b0, 3'b001, 1'b0) ^ 32'h0001_0000, "R11 upper bits mismatch");

        // R4: read cancels pending first write
        wr1(mk(2'b01, 6'd16, 3'b001, 1'b0, 3'b100, 1'b0), "R4 first write");
        step(1'b0, 1'b1, 1'b1, 32'h0, 1'b0, 2'b00, 1'b0, 1'b1, "R4 read");
        wr1(mk(2'b01, 6'd16, 3'b001, 1'b0, 3'b100, 1'b0), "R4 write after read is first");
        wr1(mk(2'b01, 6'd16, 3'b001, 1'b0, 3'b100, 1'b0), "R4 commit after fresh pair");
        // R4: read concurrent with write
        wr1(mk(2'b10, 6'd2, 3'b100, 1'b0, 3'b001, 1'b0), "R4 first write");
        step(1'b1, 1'b1, 1'b1, mk(2'b10, 6'd2, 3'b100, 1'b0, 3'b001, 1'b0),
             1'b0, 2'b00, 1'b0, 1'b1, "R4 read with write counts as first");
        wr1(mk(2'b10, 6'd2, 3'b100, 1'b0, 3'b001, 1'b0), "R4 commit after read-write cycle");

        // R5: busy writes ignored
        step(1'b1, 1'b0, 1'b0, mk(2'b01, 6'd8, 3'b100, 1'b1, 3'b010, 1'b0),
             1'b0, 2'b00, 1'b0, 1'b1, "R5 busy write 1");
        step(1'b1, 1'b0, 1'b0, mk(2'b01, 6'd8, 3'b100, 1'b1, 3'b010, 1'b0),
             1'b0, 2'b00, 1'b0, 1'b1, "R5 busy write 2");
        wr1(mk(2'b01, 6'd8, 3'b100, 1'b1, 3'b010, 1'b0), "R5 idle write after busy is first");
        wr1(mk(2'b01, 6'd8, 3'b100, 1'b1, 3'b010, 1'b0), "R5 commit once idle");
        // busy write between a pair neither commits nor cancels
        wr1(mk(2'b10, 6'd4, 3'b001, 1'b0, 3'b001, 1'b0), "R5 pair start");
        step(1'b1, 1'b0, 1'b0, 32'h1234_5678, 1'b0, 2'b00, 1'b0, 1'b1, "R5 busy mismatched write ignored");
        wr1(mk(2'b10, 6'd4, 3'b001, 1'b0, 3'b001, 1'b0), "R5 pair completes");

        // R7 operation legalization
        pair(mk(2'b00, 6'd1, 3'b001, 1'b0, 3'b001, 1'b0), "R7 op 00 to encrypt");
        pair(mk(2'b11, 6'd1, 3'b001, 1'b0, 3'b001, 1'b0), "R7 op 11 to encrypt");
        // R8 mode legalization
        pair(mk(2'b10, 6'd0, 3'b001, 1'b0, 3'b001, 1'b0), "R8 mode zero to none");
        pair(mk(2'b10, 6'd12, 3'b001, 1'b0, 3'b001, 1'b0), "R8 mode multi-hot to none");
        pair(mk(2'b10, 6'd63, 3'b001, 1'b0, 3'b001, 1'b0), "R8 mode all ones to none");
        // R9 key size legalization
        pair(mk(2'b01, 6'd16, 3'b000, 1'b0, 3'b001, 1'b0), "R9 key zero to 256");
        pair(mk(2'b01, 6'd16, 3'b011, 1'b0, 3'b001, 1'b0), "R9 key multi-hot to 256");
        pair(mk(2'b01, 6'd16, 3'b010, 1'b0, 3'b001, 1'b0), "R9 key 192 kept or forced 256");
        // R10 reseed legalization
        pair(mk(2'b01, 6'd2, 3'b001, 1'b0, 3'b000, 1'b0), "R10 rate zero to every block");
        pair(mk(2'b01, 6'd2, 3'b001, 1'b0, 3'b110, 1'b0), "R10 rate multi-hot to every block");
        pair(mk(2'b01, 6'd2, 3'b001, 1'b0, 3'b100, 1'b0), "R10 rate 8192 kept");
        // R11 flags
        pair(mk(2'b01, 6'd2, 3'b001, 1'b1, 3'b010, 1'b1), "R11 sideload and manual set");
        pair(mk(2'b01, 6'd2, 3'b001, 1'b0, 3'b010, 1'b1), "R11 sideload clear manual set");

        // R12 side register and lock
        step(1'b0, 1'b0, 1'b1, 32'h0, 1'b1, 2'b10, 1'b0, 1'b1, "R12 unlocked write");
        step(1'b0, 1'b0, 1'b1, 32'h0, 1'b0, 2'b00, 1'b1, 1'b1, "R12 writing 1 to lock no effect");
        step(1'b0, 1'b0, 0, 32'h0, 1'b1, 2'b11, 1'b0, 1'b1, "R12 write while busy still allowed");
        step(1'b0, 1'b0, 1'b1, 32'h0, 1'b0, 2'b00, 1'b1, 1'b0, "R12 lock cleared");
        step(1'b0, 1'b0, 1'b1, 32'h0, 1'b1, 2'b00, 1'b0, 1'b1, "R12 locked write ignored");
        step(1'b0, 1'b0, 1'b1, 32'h0, 1'b0, 2'b00, 1'b1, 1'b1, "R12 lock stays cleared");
        nop("R12 final state");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_errors++;
            n_checks++;
            $display("FAIL scoreboard: actual %0d items left, expected 0", exp_q.size());
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule